// File: doc/BRIEF.md
# NAND Flash Host Interface

This block is a register-mapped front end for an 8-bit NAND flash device. Software writes bytes to a command, address or write-data register. Each write is placed in a small write buffer. A pin sequencer drains the buffer one entry at a time and turns each entry into one strobe on the flash bus. A command entry raises the command-latch line during its write strobe. An address entry raises the address-latch line. A data entry raises neither. The length of a write strobe and the length of a read strobe are each set by their own field in the control register.

A read is a request followed by a poll. Software writes any value to the read-request register, which queues a read entry behind any writes still waiting. When the sequencer runs that entry, it pulls the read strobe low and samples the data bus on the last low cycle. It then stores the byte in the read-data register and raises a sticky read-ready flag.

The status register shows the synchronized ready/busy line and the buffer state. The event register holds sticky flags, each cleared by writing 1 to it. The flags cover a rising ready line, a dropped write, the buffer leaving the full state, and a captured read byte. An enable mask combines the flags into one interrupt line. A self-clearing register drives the clear of the downstream ECC generator.

Top module: `nand_host`

Register offsets (`reg_addr`):

| Offset | Register | Access | Contents |
|---|---|---|---|
| 0 | control | read/write | bits [3:0] write-strobe delay, bits [7:4] read-strobe delay, bit 8 data width, bit 9 page size (1 = 512-byte pages) |
| 1 | status | read only | bit 0 not-busy, bit 1 buffer full, bits 3:2 always 0, bit 4 buffer empty and no strobe in flight |
| 2 | event | read, write 1 to clear | bit 0 ready rose, bit 1 overflow, bit 2 full to not full, bit 3 read byte ready, bit 4 never set |
| 3 | event mask | read/write | bits [4:0] enable the matching event bits onto `irq` |
| 4 | command | write only | queues a command strobe |
| 5 | address | write only | queues an address strobe |
| 6 | write data | write only | queues a plain data strobe |
| 7 | read request | write only | queues a read strobe; the written value is ignored |
| 8 | read data | read only | bits [7:0] last captured byte |
| 9 | ECC clear | read, write bit 0 = 1 to start | bit 0 reads 1 while the clear runs |

## Requirements
- R1: After reset, `nf_ce_n`, `nf_we_n` and `nf_re_n` are 1, and `nf_cle`, `nf_ale`, `nf_dq_oe`, `irq` and `ecc_clr` are 0. Status (offset 1) reads 16'h0011 and event (offset 2) reads 0.
- R2: Control (offset 0) reads back as written in bits [9:0]. A write to the command register (offset 4) produces one strobe. During that strobe `nf_we_n` is 0 for exactly write-delay + 1 cycles, and `nf_cle` is 1, `nf_ale` is 0, `nf_dq_oe` is 1 and `nf_dq_o` equals the written byte.
- R3: A write to the address register (offset 5) produces one write strobe with `nf_ale` 1, `nf_cle` 0, and the written byte on `nf_dq_o`.
- R4: A write to the write-data register (offset 6) produces one write strobe with both `nf_cle` and `nf_ale` at 0 and the byte on `nf_dq_o`.
- R5: Any write to the read-request register (offset 7) produces one strobe. During it `nf_re_n` is 0 for read-delay + 1 cycles and `nf_we_n` stays 1. The byte on `nf_dq_i` during the last low cycle then reads from offset 8, and event bit 3 is set.
- R6: Queued entries reach the pins in write order. The buffer holds 4 entries, and status bit 1 is 1 while all 4 are occupied.
- R7: A queue write while the buffer is full is dropped, so it produces no strobe, and it sets event bit 1.
- R8: Event bit 2 is set when the buffer goes from full to not full.
- R9: Writing 1 to an event bit clears that bit. Writing 0 leaves it unchanged.
- R10: `irq` is 1 exactly when some event bit and the same mask bit (offset 3) are both 1.
- R11: Status bit 0 follows `nf_rb` after a two-stage synchronizer. Event bit 0 is set when the synchronized line rises.
- R12: Writing 1 to bit 0 of offset 9 makes that bit read 1 for exactly 4 cycles, with `ecc_clr` high for the same cycles. After that the bit returns to 0 by itself.
- R13: Status bit 4 is 0 while any entry is queued or a strobe is in flight. Status bits 3:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register write strobe, one cycle per write |
| reg_addr | input | 4 | register offset |
| reg_wdata | input | 16 | register write data |
| reg_rdata | output | 16 | register read data (combinational from `reg_addr`) |
| nf_ce_n | output | 1 | flash chip enable, active low |
| nf_cle | output | 1 | command latch enable |
| nf_ale | output | 1 | address latch enable |
| nf_we_n | output | 1 | write strobe, active low |
| nf_re_n | output | 1 | read strobe, active low |
| nf_rb | input | 1 | ready/busy from flash, 1 = ready |
| nf_dq_o | output | 8 | data bus out |
| nf_dq_oe | output | 1 | data bus output enable |
| nf_dq_i | input | 8 | data bus in |
| ecc_clr | output | 1 | clear for the ECC accumulators |
| irq | output | 1 | masked OR of the event flags |

## Verification
The bench measures every strobe at the pins: its width in cycles, its latch lines and its byte. A design that miscounted the delay by one cycle, or swapped the command and address latch lines, shows up as a wrong width or a wrong line. Six back-to-back data writes are issued against the longest write delay. A design that wrapped its buffer or accepted the sixth write would emit six strobes or reorder the bytes, and a design that never left the full state would never set the edge flag. The bench also checks the parts that act on one bit at a time. It writes zeros to the event register, where a design that cleared on any write would lose flags. It changes the mask with flags pending, and it counts the cycles that the self-clearing ECC bit stays high.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;

   typedef enum logic [1:0] {
      OP_CMD  = 2'd0,
      OP_ADDR = 2'd1,
      OP_WR   = 2'd2,
      OP_RD   = 2'd3
   } nf_op_e;

   typedef struct packed {
      nf_op_e     op;
      logic [7:0] val;
   } wb_entry_t;

   localparam logic [3:0] RA_CTRL   = 4'd0;
   localparam logic [3:0] RA_STAT   = 4'd1;
   localparam logic [3:0] RA_EVT    = 4'd2;
   localparam logic [3:0] RA_EVMASK = 4'd3;
   localparam logic [3:0] RA_CMD    = 4'd4;
   localparam logic [3:0] RA_ADDR   = 4'd5;
   localparam logic [3:0] RA_WDATA  = 4'd6;
   localparam logic [3:0] RA_RDREQ  = 4'd7;
   localparam logic [3:0] RA_RDATA  = 4'd8;
   localparam logic [3:0] RA_ECCRST = 4'd9;

   localparam int unsigned EV_W      = 5;
   localparam int unsigned EV_RB     = 0;
   localparam int unsigned EV_OVF    = 1;
   localparam int unsigned EV_EDGE   = 2;
   localparam int unsigned EV_RDRDY  = 3;

endpackage

// File: rtl/nand_wbuf.sv
module nand_wbuf
   import nand_host_pkg::*;
#(
   parameter int unsigned DEPTH = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      push,
   input  wb_entry_t din,
   input  logic      pop,
   output wb_entry_t dout,
   output logic      full,
   output logic      empty
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam bit          POW2 = (DEPTH & (DEPTH - 1)) == 0;

   generate
      if (DEPTH < 2) begin : g_depth_bad
         $error("nand_wbuf: DEPTH must be at least 2");
      end
   endgenerate

   wb_entry_t       mem [DEPTH];
   logic [PW-1:0]   wptr, rptr, wptr_nx, rptr_nx;
   logic [CW-1:0]   cnt;

   generate
      if (POW2) begin : g_wrap_nat
         assign wptr_nx = wptr + 1'b1;
         assign rptr_nx = rptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wptr_nx = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rptr_nx = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (push) wptr <= wptr_nx;
         if (pop)  rptr <= rptr_nx;
         if (push && !pop)      cnt <= cnt + 1'b1;
         else if (pop && !push) cnt <= cnt - 1'b1;
      end
   end

   assign dout  = mem[rptr];
   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);

endmodule

// File: rtl/nand_pin_seq.sv
module nand_pin_seq
   import nand_host_pkg::*;
#(
   parameter int unsigned DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             avail,
   input  wb_entry_t        ent,
   input  logic [DLY_W-1:0] wr_dly,
   input  logic [DLY_W-1:0] rd_dly,
   input  logic [7:0]       dq_i,
   output logic             pop,
   output logic             busy,
   output logic             cle,
   output logic             ale,
   output logic             we_n,
   output logic             re_n,
   output logic [7:0]       dq_o,
   output logic             dq_oe,
   output logic             rd_done,
   output logic [7:0]       rd_byte
);
   logic             active;
   wb_entry_t        cur;
   logic [DLY_W-1:0] cnt;
   logic             is_rd;

   assign pop   = !active && avail;
   assign is_rd = (cur.op == OP_RD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         cur     <= '{op: OP_CMD, val: 8'h00};
         cnt     <= '0;
         rd_done <= 1'b0;
         rd_byte <= 8'h00;
      end else begin
         rd_done <= 1'b0;
         if (pop) begin
            active <= 1'b1;
            cur    <= ent;
            cnt    <= (ent.op == OP_RD) ? rd_dly : wr_dly;
         end else if (active) begin
            if (cnt == '0) begin
               active <= 1'b0;
               if (is_rd) begin
                  rd_byte <= dq_i;
                  rd_done <= 1'b1;
               end
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   assign busy  = active;
   assign we_n  = !(active && !is_rd);
   assign re_n  = !(active && is_rd);
   assign cle   = active && (cur.op == OP_CMD);
   assign ale   = active && (cur.op == OP_ADDR);
   assign dq_oe = active && !is_rd;
   assign dq_o  = dq_oe ? cur.val : 8'h00;

endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rb_async,
   output logic rb_sync
);
   generate
      if (STAGES < 2) begin : g_stages_bad
         $error("nand_rb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], rb_async};
   end

   assign rb_sync = sh[STAGES-1];

endmodule

// File: rtl/nand_host.sv
module nand_host
   import nand_host_pkg::*;
#(
   parameter int unsigned WB_DEPTH    = 4,
   parameter int unsigned DLY_W       = 4,
   parameter int unsigned ECC_CLR_CYC = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BUS_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [3:0]       reg_addr,
   input  logic [BUS_W-1:0] reg_wdata,
   output logic [BUS_W-1:0] reg_rdata,
   output logic             nf_ce_n,
   output logic             nf_cle,
   output logic             nf_ale,
   output logic             nf_we_n,
   output logic             nf_re_n,
   input  logic             nf_rb,
   output logic [7:0]       nf_dq_o,
   output logic             nf_dq_oe,
   input  logic [7:0]       nf_dq_i,
   output logic             ecc_clr,
   output logic             irq
);
   localparam int unsigned CTRL_W = 2 * DLY_W + 2;
   localparam int unsigned EC_W   = $clog2(ECC_CLR_CYC + 1);

   generate
      if (BUS_W < CTRL_W || BUS_W < 8) begin : g_bus_bad
         $error("nand_host: BUS_W too narrow for control register");
      end
      if (ECC_CLR_CYC < 1) begin : g_ecc_bad
         $error("nand_host: ECC_CLR_CYC must be at least 1");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic [EV_W-1:0]   ev_q, ev_mask_q, ev_set, ev_clr;
   logic [EC_W-1:0]   ecc_cnt;
   logic              wb_full, wb_empty, wb_full_q, wb_pop, wb_push;
   logic              q_req, seq_busy, rd_done, rb_s, rb_q;
   logic [7:0]        rd_byte;
   wb_entry_t         wb_in, wb_out;
   nf_op_e            in_op;

   // register write decode
   always_comb begin
      q_req = 1'b0;
      in_op = OP_CMD;
      unique case (reg_addr)
         RA_CMD:   begin q_req = reg_wr; in_op = OP_CMD;  end
         RA_ADDR:  begin q_req = reg_wr; in_op = OP_ADDR; end
         RA_WDATA: begin q_req = reg_wr; in_op = OP_WR;   end
         RA_RDREQ: begin q_req = reg_wr; in_op = OP_RD;   end
         default:  ;
      endcase
   end

   assign wb_push = q_req && !wb_full;
   assign wb_in   = '{op: in_op, val: (in_op == OP_RD) ? 8'h00 : reg_wdata[7:0]};

   nand_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wb_push),
      .din   (wb_in),
      .pop   (wb_pop),
      .dout  (wb_out),
      .full  (wb_full),
      .empty (wb_empty)
   );

   nand_pin_seq #(.DLY_W(DLY_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .avail   (!wb_empty),
      .ent     (wb_out),
      .wr_dly  (ctrl_q[DLY_W-1:0]),
      .rd_dly  (ctrl_q[2*DLY_W-1:DLY_W]),
      .dq_i    (nf_dq_i),
      .pop     (wb_pop),
      .busy    (seq_busy),
      .cle     (nf_cle),
      .ale     (nf_ale),
      .we_n    (nf_we_n),
      .re_n    (nf_re_n),
      .dq_o    (nf_dq_o),
      .dq_oe   (nf_dq_oe),
      .rd_done (rd_done),
      .rd_byte (rd_byte)
   );

   nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rbs (
      .clk      (clk),
      .rst_n    (rst_n),
      .rb_async (nf_rb),
      .rb_sync  (rb_s)
   );

   // sticky events: set has priority over write-one-to-clear
   always_comb begin
      ev_set           = '0;
      ev_set[EV_RB]    = rb_s && !rb_q;
      ev_set[EV_OVF]   = q_req && wb_full;
      ev_set[EV_EDGE]  = wb_full_q && !wb_full;
      ev_set[EV_RDRDY] = rd_done;
      ev_clr = (reg_wr && reg_addr == RA_EVT) ? reg_wdata[EV_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         ev_q      <= '0;
         ev_mask_q <= '0;
         wb_full_q <= 1'b0;
         rb_q      <= 1'b1;
         ecc_cnt   <= '0;
      end else begin
         wb_full_q <= wb_full;
         rb_q      <= rb_s;
         ev_q      <= ev_set | (ev_q & ~ev_clr);
         if (reg_wr && reg_addr == RA_CTRL)   ctrl_q    <= reg_wdata[CTRL_W-1:0];
         if (reg_wr && reg_addr == RA_EVMASK) ev_mask_q <= reg_wdata[EV_W-1:0];
         if (reg_wr && reg_addr == RA_ECCRST && reg_wdata[0])
            ecc_cnt <= EC_W'(ECC_CLR_CYC);
         else if (ecc_cnt != '0)
            ecc_cnt <= ecc_cnt - 1'b1;
      end
   end

   assign ecc_clr = (ecc_cnt != '0);
   assign irq     = |(ev_q & ev_mask_q);
   assign nf_ce_n = !(seq_busy || !wb_empty);

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl_q;
         RA_STAT:   begin
            reg_rdata[0] = rb_s;
            reg_rdata[1] = wb_full;
            reg_rdata[4] = wb_empty && !seq_busy;
         end
         RA_EVT:    reg_rdata[EV_W-1:0] = ev_q;
         RA_EVMASK: reg_rdata[EV_W-1:0] = ev_mask_q;
         RA_RDATA:  reg_rdata[7:0] = rd_byte;
         RA_ECCRST: reg_rdata[0] = ecc_clr;
         default:   ;
      endcase
   end

endmodule

// File: rtl/nand_host_chk.sv
module nand_host_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        nf_we_n,
   input logic        nf_re_n,
   input logic        nf_cle,
   input logic        nf_ale,
   input logic        nf_ce_n,
   input logic        nf_dq_oe,
   input logic        q_req,
   input logic        wb_full,
   input logic        reg_wr,
   input logic [3:0]  reg_addr,
   input logic [15:0] reg_wdata,
   input logic [4:0]  ev_q
);
   // R2 / R5: a write strobe and a read strobe never overlap
   a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nf_we_n && !nf_re_n));

   // R3: command and address latch never together
   a_r3_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(nf_cle && nf_ale));

   // R2: bus driven whenever the write strobe is low
   a_r2_drive_on_we: assert property (@(posedge clk) disable iff (!rst_n)
      !nf_we_n |-> nf_dq_oe);

   // R6: chip enabled during any strobe
   a_r6_ce_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

   // R7: a queue write into a full buffer flags overflow
   a_r7_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (q_req && wb_full) |=> ev_q[1]);

   // R9: overflow flag persists until a one is written to it
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_q[1] && !(reg_wr && reg_addr == 4'd2 && reg_wdata[1])) |=> ev_q[1]);

endmodule

bind nand_host nand_host_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .nf_we_n   (nf_we_n),
   .nf_re_n   (nf_re_n),
   .nf_cle    (nf_cle),
   .nf_ale    (nf_ale),
   .nf_ce_n   (nf_ce_n),
   .nf_dq_oe  (nf_dq_oe),
   .q_req     (q_req),
   .wb_full   (wb_full),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata[15:0]),
   .ev_q      (ev_q)
);

// File: tb/nand_host_tb.sv
module nand_host_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, ecc_clr, irq;
   logic        nf_rb = 1'b1;
   logic [7:0]  nf_dq_o;
   logic [7:0]  nf_dq_i = 8'h00;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_host u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nf_ce_n(nf_ce_n),
      .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
      .nf_rb(nf_rb), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i),
      .ecc_clr(ecc_clr), .irq(irq)
   );

   // strobe monitor: kind 0 cmd, 1 addr, 2 data, 3 read
   int   s_n = 0;
   int   cur_len = 0;
   int   s_kind [16];
   int   s_val  [16];
   int   s_wid  [16];

   always @(negedge clk) begin
      if (!nf_we_n || !nf_re_n) begin
         if (cur_len == 0 && s_n < 16) begin
            s_kind[s_n] = !nf_re_n ? 3 : nf_cle ? 0 : nf_ale ? 1 : 2;
            s_val[s_n]  = nf_dq_o;
         end
         cur_len++;
      end else if (cur_len > 0) begin
         if (s_n < 16) s_wid[s_n] = cur_len;
         s_n++;
         cur_len = 0;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [15:0] st;
      for (int i = 0; i < 2000; i++) begin
         bus_rd(4'd1, st);
         if (st[4]) break;
         @(negedge clk);
      end
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      check(nf_ce_n && nf_we_n && nf_re_n, "R1 strobes idle", {nf_ce_n, nf_we_n, nf_re_n}, 7);
      check(!nf_cle && !nf_ale && !nf_dq_oe && !irq && !ecc_clr, "R1 lines low",
            {nf_cle, nf_ale, nf_dq_oe, irq, ecc_clr}, 0);
      bus_rd(4'd1, v);  check(v == 16'h0011, "R1 status", v, 16'h0011);
      bus_rd(4'd2, v);  check(v == 16'h0000, "R1 event", v, 0);
   endtask

   task automatic t_cmd();
      logic [15:0] v;
      bus_wr(4'd0, 16'h0332);
      bus_rd(4'd0, v); check(v == 16'h0332, "R2 ctrl readback", v, 16'h0332);
      s_n = 0;
      bus_wr(4'd4, 16'h0090);
      wait_idle();
      check(s_n == 1, "R2 strobe count", s_n, 1);
      check(s_kind[0] == 0, "R2 cle strobe", s_kind[0], 0);
      check(s_val[0] == 8'h90, "R2 byte", s_val[0], 8'h90);
      check(s_wid[0] == 3, "R2 width", s_wid[0], 3);
   endtask

   task automatic t_addr_data();
      bus_wr(4'd0, 16'h0000);
      s_n = 0;
      bus_wr(4'd5, 16'h0012);
      bus_wr(4'd6, 16'h00A5);
      wait_idle();
      check(s_n == 2, "R3 strobe count", s_n, 2);
      check(s_kind[0] == 1 && s_val[0] == 8'h12, "R3 addr strobe", s_val[0], 8'h12);
      check(s_kind[1] == 2 && s_val[1] == 8'hA5, "R4 data strobe", s_val[1], 8'hA5);
      check(s_wid[1] == 1, "R4 width", s_wid[1], 1);
   endtask

   task automatic t_read();
      logic [15:0] v;
      bus_wr(4'd0, 16'h0030);
      bus_wr(4'd2, 16'h001F);
      nf_dq_i = 8'h5C;
      s_n = 0;
      bus_wr(4'd7, 16'hFFFF);
      wait_idle();
      check(s_n == 1 && s_kind[0] == 3, "R5 read strobe", s_kind[0], 3);
      check(s_wid[0] == 4, "R5 width", s_wid[0], 4);
      bus_rd(4'd8, v); check(v == 16'h005C, "R5 read data", v, 16'h005C);
      bus_rd(4'd2, v); check(v[3], "R5 ready flag", v, 16'h0008);
   endtask

   task automatic t_fifo();
      logic [15:0] v;
      bus_wr(4'd0, 16'h000F);
      bus_wr(4'd2, 16'h001F);
      s_n = 0;
      for (int i = 1; i <= 6; i++) bus_wr(4'd6, 16'(i));
      bus_rd(4'd1, v); check(v[1], "R6 full flag", v, 16'h0002);
      check(!v[4], "R13 not empty", v, 0);
      check(v[3:2] == 2'b00, "R13 page bits zero", v[3:2], 0);
      bus_rd(4'd2, v); check(v[1], "R7 overflow flag", v, 16'h0002);
      check(!v[2], "R8 edge not yet", v, 0);
      wait_idle();
      check(s_n == 5, "R7 dropped write", s_n, 5);
      for (int i = 0; i < 5; i++)
         check(s_val[i] == i + 1, "R6 order", s_val[i], i + 1);
      bus_rd(4'd2, v); check(v[2], "R8 edge flag", v, 16'h0004);
   endtask

   task automatic t_w1c_irq();
      logic [15:0] v;
      bus_wr(4'd2, 16'h0000);
      bus_rd(4'd2, v); check(v[2:1] == 2'b11, "R9 zero write keeps", v, 16'h0006);
      bus_wr(4'd2, 16'h0002);
      bus_rd(4'd2, v); check(v[2:1] == 2'b10, "R9 one clears", v, 16'h0004);
      check(!irq, "R10 masked", irq, 0);
      bus_wr(4'd3, 16'h0004);
      #1; check(irq, "R10 enabled", irq, 1);
      bus_wr(4'd2, 16'h0004);
      #1; check(!irq, "R10 cleared", irq, 0);
      bus_wr(4'd3, 16'h0000);
   endtask

   task automatic t_rb();
      logic [15:0] v;
      bus_wr(4'd2, 16'h001F);
      nf_rb = 1'b0;
      repeat (4) @(negedge clk);
      bus_rd(4'd1, v); check(!v[0], "R11 busy seen", v[0], 0);
      bus_rd(4'd2, v); check(!v[0], "R11 no rise yet", v[0], 0);
      nf_rb = 1'b1;
      repeat (4) @(negedge clk);
      bus_rd(4'd1, v); check(v[0], "R11 ready seen", v[0], 1);
      bus_rd(4'd2, v); check(v[0], "R11 rise flag", v[0], 1);
   endtask

   task automatic t_ecc();
      logic [15:0] v;
      int n = 0;
      bus_wr(4'd9, 16'h0001);
      check(ecc_clr, "R12 clear active", ecc_clr, 1);
      bus_rd(4'd9, v);
      while (v[0] && n < 100) begin
         n++;
         @(negedge clk);
         bus_rd(4'd9, v);
      end
      check(n == 4, "R12 clear cycles", n, 4);
      check(!ecc_clr, "R12 clear done", ecc_clr, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cmd();
      t_addr_data();
      t_read();
      t_fifo();
      t_w1c_irq();
      t_rb();
      t_ecc();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule